// File: doc/BRIEF.md
# GPIO Port Register Bank with Masked Writes

This block holds the pin-control registers for one GPIO bank of 32 pins, organised as four ports of eight pins. Each port owns a configuration register (a 1 hands the pin to GPIO control, a 0 leaves it with the alternate function), an output-enable register, an output-data register and a read-only input register. A simple memory-mapped bus reads and writes these registers. The block drives the pad output values and pad output enables, and it samples the pad levels through a two-flop synchroniser.

A second address window, placed at a parameterised offset above the normal one, aliases the writable registers for masked writes. In this window the upper byte of the write data chooses which pins the lower byte updates. Software can therefore change a single pin without a read-modify-write and without racing other agents that touch the same port. Pin number p maps to port p[4:3] and bit p[2:0], which is pad index p.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every configuration, output-enable and output-data register reads 0, and pad_oe and pad_out are all 0.
- R2: Register addresses are port*4 plus a kind offset: 0x00 configuration, 0x10 output enable, 0x20 output data, 0x30 input. A normal write replaces all 8 bits with bus_wdata[7:0] and ignores the higher bits. The read of a mapped register returns its 8 bits in bus_rdata[7:0] with bus_rdata[31:8] = 0, and bus_rvalid is high in the single cycle after the clock edge that takes the read request.
- R3: A write at a normal address plus MASK_OFFSET is masked. Bit 8+i of the write data enables pin i, and bit i gives its new value. A pin whose enable bit is 0 keeps its value.
- R4: pad_oe[p] is 1 exactly when both the configuration bit and the output-enable bit of pin p are 1. It updates in the cycle after the write.
- R5: pad_out[p] follows the output-data bit of pin p whatever the pin's enables are.
- R6: A pad level passes through two flops before the input register. A read request taken one clock edge after the level changes still returns the old level. A level held for three or more cycles before the read request is returned.
- R7: Writes to the input register are ignored, in both the normal and the masked window.
- R8: Reads of unmapped or misaligned offsets, and all reads in the masked window, return 0. Writes to unmapped or misaligned offsets change no register.
- R9: Setting a pin as an output (output value, then output enable, then configuration, each as a masked write) drives the pad with that value. Setting it back as an input clears its output enable and drops pad_oe for that pin only.
- R10: Pin p is controlled by bit p[2:0] of the port p[4:3] registers and appears at pad index p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the request |
| bus_wdata | input | DATA_W | Write data (masked window: [15:8] enables, [7:0] values) |
| bus_rdata | output | DATA_W | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| pad_in | input | NUM_PORTS*PINS | Asynchronous pad levels |
| pad_out | output | NUM_PORTS*PINS | Pad output values |
| pad_oe | output | NUM_PORTS*PINS | Pad output enables |

## Verification
The bench uses the defaults: four ports of eight pins, an 8-bit address and a masked window at 0x80. With this address width, the unused gap between 0x40 and 0x7F and the misaligned addresses can be reached, as can reads that fall in the masked window. Because the window offset is a single address bit, one masked write to the input alias and one to an unmapped alias cover the decode of every alias. The 0x800 variant differs only in ADDR_W and MASK_OFFSET. The pad pattern 0xDEADBEEF gives every port a distinct input byte, so a port swap shows up in the readback.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [1:0] {
        REG_CFG = 2'd0,
        REG_OE  = 2'd1,
        REG_OUT = 2'd2,
        REG_IN  = 2'd3
    } gpio_reg_e;

    typedef struct packed {
        logic      hit;
        logic      masked;
        gpio_reg_e kind;
    } gpio_dec_t;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int NUM_PORTS   = 4,
    parameter int MASK_OFFSET = 128,
    localparam int PORT_W     = $clog2(NUM_PORTS)
) (
    input  logic [ADDR_W-1:0] addr,
    output gpio_dec_t         dec,
    output logic [PORT_W-1:0] port_idx
);
    // word select in [1:0], port in [PORT_W+1:2], register kind above it
    localparam int KIND_LSB  = 2 + PORT_W;
    localparam int FIELD_TOP = KIND_LSB + 2;
    localparam logic [ADDR_W-1:0] FIELD_BITS = ADDR_W'(((1 << FIELD_TOP) - 1) ^ 3);
    localparam logic [ADDR_W-1:0] ALIAS_BIT  = ADDR_W'(MASK_OFFSET);

    always_comb begin
        port_idx   = addr[2 +: PORT_W];
        dec.kind   = gpio_reg_e'(addr[KIND_LSB +: 2]);
        dec.masked = |(addr & ALIAS_BIT);
        dec.hit    = ((addr & ~(FIELD_BITS | ALIAS_BIT)) == '0)
                     && (int'(port_idx) < NUM_PORTS);
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.meta   = d;
        sync_d.stable = sync_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign q = sync_q.stable;

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_cfg,
    input  logic            wr_oe,
    input  logic            wr_out,
    input  logic [PINS-1:0] wr_mask,
    input  logic [PINS-1:0] wr_val,
    output logic [PINS-1:0] cfg,
    output logic [PINS-1:0] oe,
    output logic [PINS-1:0] dout
);
    typedef struct packed {
        logic [PINS-1:0] cfg;
        logic [PINS-1:0] oe;
        logic [PINS-1:0] dout;
    } port_t;

    port_t st_d, st_q;

    function automatic logic [PINS-1:0] merge(input logic [PINS-1:0] old_v);
        return (old_v & ~wr_mask) | (wr_val & wr_mask);
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr_cfg) st_d.cfg  = merge(st_q.cfg);
        if (wr_oe)  st_d.oe   = merge(st_q.oe);
        if (wr_out) st_d.dout = merge(st_q.dout);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg  = st_q.cfg;
    assign oe   = st_q.oe;
    assign dout = st_q.dout;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int NUM_PORTS   = 4,
    parameter int PINS        = 8,
    parameter int DATA_W      = 32,
    parameter int MASK_OFFSET = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic                      bus_rvalid,
    input  logic [NUM_PORTS*PINS-1:0] pad_in,
    output logic [NUM_PORTS*PINS-1:0] pad_out,
    output logic [NUM_PORTS*PINS-1:0] pad_oe
);
    localparam int NPINS  = NUM_PORTS * PINS;
    localparam int PORT_W = $clog2(NUM_PORTS);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_t;

    gpio_dec_t         dec;
    logic [PORT_W-1:0] port_idx;
    logic [NPINS-1:0]  pad_sync;
    logic              wr_go;
    logic [PINS-1:0]   wr_mask;
    logic [PINS-1:0]   wr_val;
    logic [PINS-1:0]   cfg_a [NUM_PORTS];
    logic [PINS-1:0]   oe_a  [NUM_PORTS];
    logic [PINS-1:0]   out_a [NUM_PORTS];
    logic              unused_wdata_hi;
    rd_t               rd_d, rd_q;

    gpio_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .MASK_OFFSET(MASK_OFFSET)
    ) u_dec (
        .addr(bus_addr), .dec(dec), .port_idx(port_idx)
    );

    gpio_in_sync #(.WIDTH(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
    );

    assign wr_go           = bus_sel & bus_wr & dec.hit;
    assign wr_mask         = dec.masked ? bus_wdata[2*PINS-1:PINS] : '1;
    assign wr_val          = bus_wdata[PINS-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:2*PINS];

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        logic sel;
        assign sel = wr_go && (port_idx == PORT_W'(g));

        gpio_port_regs #(.PINS(PINS)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_cfg (sel && (dec.kind == REG_CFG)),
            .wr_oe  (sel && (dec.kind == REG_OE)),
            .wr_out (sel && (dec.kind == REG_OUT)),
            .wr_mask(wr_mask),
            .wr_val (wr_val),
            .cfg    (cfg_a[g]),
            .oe     (oe_a[g]),
            .dout   (out_a[g])
        );

        assign pad_oe [g*PINS +: PINS] = cfg_a[g] & oe_a[g];
        assign pad_out[g*PINS +: PINS] = out_a[g];
    end

    always_comb begin
        rd_d.valid = bus_sel & ~bus_wr;
        rd_d.data  = '0;
        if (bus_sel && !bus_wr && dec.hit && !dec.masked) begin
            for (int i = 0; i < NUM_PORTS; i++) begin
                if (port_idx == PORT_W'(i)) begin
                    case (dec.kind)
                        REG_CFG: rd_d.data[PINS-1:0] = cfg_a[i];
                        REG_OE:  rd_d.data[PINS-1:0] = oe_a[i];
                        REG_OUT: rd_d.data[PINS-1:0] = out_a[i];
                        default: rd_d.data[PINS-1:0] = pad_sync[i*PINS +: PINS];
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata  = rd_q.data;
    assign bus_rvalid = rd_q.valid;

endmodule

// File: rtl/gpio_bank_regs_checker.sv
module gpio_bank_regs_checker #(
    parameter int ADDR_W      = 8,
    parameter int NUM_PORTS   = 4,
    parameter int PINS        = 8,
    parameter int DATA_W      = 32,
    parameter int MASK_OFFSET = 128
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_sel,
    input logic                      bus_wr,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [DATA_W-1:0]         bus_wdata,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic                      bus_rvalid,
    input logic [NUM_PORTS*PINS-1:0] pad_out,
    input logic [NUM_PORTS*PINS-1:0] pad_oe
);
    localparam logic [ADDR_W-1:0] ALIAS_BIT = ADDR_W'(MASK_OFFSET);

    // R2: a read request yields exactly one rvalid on the next cycle
    a_r2_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);
    a_r2_no_stray_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);
    // R2: only the low pin byte can carry data
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (bus_rdata[DATA_W-1:PINS] == '0));
    // R3: a masked write with no enable bit set changes no pad
    a_r3_empty_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && ((bus_addr & ALIAS_BIT) != '0) && (bus_wdata[2*PINS-1:PINS] == '0))
        |=> ($stable(pad_out) && $stable(pad_oe)));
    // R4 R5: pads only move after a write
    a_r5_pads_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> ($stable(pad_out) && $stable(pad_oe)));
    // R8: misaligned reads return zero
    a_r8_misaligned_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr[1:0] != 2'b00)) |=> (bus_rdata == '0));
    // R8: reads in the masked window return zero
    a_r8_alias_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && ((bus_addr & ALIAS_BIT) != '0)) |=> (bus_rdata == '0));

endmodule

bind gpio_bank_regs gpio_bank_regs_checker #(
    .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .PINS(PINS),
    .DATA_W(DATA_W), .MASK_OFFSET(MASK_OFFSET)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/gpio_bank_regs_tb_top.sv
module gpio_bank_regs_tb_top;
    localparam int AW = 8;
    localparam int NP = 4;
    localparam int PN = 8;
    localparam int DW = 32;
    localparam int MO = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_rvalid;
    logic [31:0]   pad_in = '0;
    logic [31:0]   pad_out;
    logic [31:0]   pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    logic [7:0] cfg_m [NP];
    logic [7:0] oe_m  [NP];
    logic [7:0] out_m [NP];

    always #10 clk = ~clk;   // 50 MHz

    gpio_bank_regs #(.ADDR_W(AW), .NUM_PORTS(NP), .PINS(PN), .DATA_W(DW), .MASK_OFFSET(MO)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever read data comes back
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R2 stray rvalid", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic raw_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    function automatic logic [AW-1:0] reg_addr(input int kind, input int port, input bit masked);
        return AW'(kind * 16 + port * 4 + (masked ? MO : 0));
    endfunction

    // kinds: 0 cfg, 1 oe, 2 out (R2 offsets); model follows R2/R3
    task automatic mwrite(input int kind, input int port, input bit masked, input logic [31:0] d);
        logic [7:0] en;
        logic [7:0] old;
        en  = masked ? d[15:8] : 8'hFF;
        old = (kind == 0) ? cfg_m[port] : (kind == 1) ? oe_m[port] : out_m[port];
        old = (old & ~en) | (d[7:0] & en);
        if (kind == 0) cfg_m[port] = old;
        else if (kind == 1) oe_m[port] = old;
        else out_m[port] = old;
        raw_write(reg_addr(kind, port, masked), d);
    endtask

    task automatic check_pads(input string tag);
        logic [31:0] eo, ev;
        for (int p = 0; p < NP; p++) begin
            eo[p*8 +: 8] = cfg_m[p] & oe_m[p];
            ev[p*8 +: 8] = out_m[p];
        end
        check({tag, " pad_oe"}, pad_oe, eo);
        check({tag, " pad_out"}, pad_out, ev);
    endtask

    task automatic read_all(input string tag);
        for (int p = 0; p < NP; p++) begin
            do_read(reg_addr(0, p, 0), {24'd0, cfg_m[p]}, tag);
            do_read(reg_addr(1, p, 0), {24'd0, oe_m[p]}, tag);
            do_read(reg_addr(2, p, 0), {24'd0, out_m[p]}, tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            cfg_m[p] = '0; oe_m[p] = '0; out_m[p] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_pads("R1 reset");
        read_all("R1 reset readback");
        for (int p = 0; p < NP; p++) do_read(reg_addr(3, p, 0), 32'd0, "R1 input at reset");

        // R2 normal writes, upper data ignored
        mwrite(2, 0, 0, 32'h0000_00A5);
        mwrite(1, 1, 0, 32'h0000_003C);
        mwrite(0, 2, 0, 32'h0000_00F0);
        mwrite(0, 3, 0, 32'hFFFF_FF81);
        mwrite(2, 3, 0, 32'h1234_5600);
        read_all("R2 normal write readback");
        check_pads("R4 oe needs cfg");
        mwrite(0, 1, 0, 32'h0000_000F);
        check_pads("R4 cfg and oe");
        mwrite(1, 3, 0, 32'h0000_00FF);
        check_pads("R5 out with oe");

        // R3 masked writes
        mwrite(2, 0, 1, 32'h0000_0F0A);
        do_read(reg_addr(2, 0, 0), 32'h0000_00AA, "R3 masked merge");
        mwrite(2, 0, 1, 32'h0000_00FF);
        do_read(reg_addr(2, 0, 0), 32'h0000_00AA, "R3 empty mask keeps");
        mwrite(2, 3, 1, 32'h0000_8080);
        do_read(reg_addr(2, 3, 0), 32'h0000_0080, "R3 single pin set");
        check_pads("R3 pads after masked writes");

        // R6 input synchroniser latency and value
        pad_in = 32'hDEADBEEF;
        do_read(reg_addr(3, 0, 0), 32'h0000_0000, "R6 two-flop latency");
        repeat (3) @(negedge clk);
        do_read(reg_addr(3, 0, 0), 32'h0000_00EF, "R6 port0 input");
        do_read(reg_addr(3, 1, 0), 32'h0000_00BE, "R6 port1 input");
        do_read(reg_addr(3, 2, 0), 32'h0000_00AD, "R6 port2 input");
        do_read(reg_addr(3, 3, 0), 32'h0000_00DE, "R6 port3 input");

        // R7 input register not writable
        raw_write(reg_addr(3, 0, 0), 32'h0000_0000);
        raw_write(reg_addr(3, 1, 1), 32'h0000_FF00);
        do_read(reg_addr(3, 0, 0), 32'h0000_00EF, "R7 normal write to input ignored");
        do_read(reg_addr(3, 1, 0), 32'h0000_00BE, "R7 masked write to input ignored");
        check_pads("R7 pads untouched");

        // R8 unmapped and misaligned
        do_read(8'h40, 32'd0, "R8 unmapped read");
        do_read(8'h21, 32'd0, "R8 misaligned read");
        do_read(reg_addr(2, 0, 1), 32'd0, "R8 masked window read");
        raw_write(8'h40, 32'h0000_00FF);
        raw_write(8'h21, 32'h0000_00FF);
        raw_write(8'hC4, 32'h0000_FFFF);
        check_pads("R8 unmapped writes ignored");
        read_all("R8 registers unchanged");

        // R9 R10 pin 13 as output high, then back to input
        begin
            int pin = 13;
            int pt  = (pin >> 3) & 3;
            logic [31:0] md = {16'd0, 8'(1 << (pin & 7)), 8'(1 << (pin & 7))};
            mwrite(2, pt, 1, md);
            mwrite(1, pt, 1, md);
            mwrite(0, pt, 1, md);
            check("R9 pin13 oe", {31'd0, pad_oe[pin]}, 32'd1);
            check("R10 pin13 value", {31'd0, pad_out[pin]}, 32'd1);
            check_pads("R10 other pins unchanged");
            mwrite(1, pt, 1, md & 32'h0000_FF00);
            mwrite(0, pt, 1, md);
            check("R9 pin13 input", {31'd0, pad_oe[pin]}, 32'd0);
            check_pads("R9 after input config");
        end

        repeat (4) @(negedge clk);
        check("R2 all reads answered", exp_q.size(), 32'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule